// File: doc/BRIEF.md
# Chained Performance Event Counter Bank

This block holds a set of programmable event counters and one free-running cycle counter at index 31. Software configures the bank through a single-cycle register port. It sets a global run bit, per-counter enable masks, an event number for each programmable counter, interrupt enables and counter values. Hardware sends event pulses that carry an event number. Any enabled counter whose programmed number matches the pulse advances by one. A write to the software-increment register advances every selected counter that is programmed with the software event.

Each counter wraps either at 32 or at 64 bits, as the control register selects. A wrap sets a sticky status bit. An even programmable counter that wraps at 32 bits sends one chain event to its odd neighbour in the same cycle, so each pair can form a wider count. The interrupt output is a level. It is high while the bank runs and any enabled status bit is set.

Top module: `pmc_bank`

## Requirements
- R1: A counter advances only while the control run bit (bit 0) is 1, its bit in the enable mask is 1, and its index lies inside the valid mask. The enable mask is written as set-by-one at address 0x01 and clear-by-one at 0x02.
- R2: The event type register of programmable counter i is at address 0x20+i. It stores the event number masked to 16 bits when EVT_WIDE=1 or to 10 bits when EVT_WIDE=0. A pulse on evt_valid advances the counter when the masked evt_num equals the stored type.
- R3: The cycle counter (counter address 0x5F) is 64 bits wide and advances once every clock while it is enabled. Programmable counters (address 0x40+i) hold 64 bits when WIDE_CTR=1 and only 32 bits when WIDE_CTR=0.
- R4: A programmable counter overflows when all 64 bits wrap to zero if control bit 7 (LP) is 1, and otherwise when its low 32 bits wrap to zero. The cycle counter follows the same rule using control bit 6 (LC).
- R5: When even counter i overflows while LP is 0, and i+1 is a programmable counter whose type is the chain event 0x001E, counter i+1 advances by one.
- R6: A write to address 0x07 advances every enabled counter whose bit is 1 in the written value and whose type is the software event 0x0000. The cycle counter is not affected.
- R7: Writing control bit 2 clears the cycle counter. Writing control bit 1 clears every valid programmable counter. Neither bit reads back as 1. LP reads back as 0 when WIDE_CTR=0.
- R8: Control bits 15:11 hold the counter count N, which resets to NUM_PROG. The valid mask is bits 0 to N-1 (limited to NUM_PROG) plus bit 31.
- R9: irq is 1 exactly when the run bit is 1 and the overflow status ANDed with the interrupt enables is nonzero. The interrupt enables are set-by-one at 0x05 and clear-by-one at 0x06.
- R10: With wr_narrow=1, a write to a programmable counter replaces only bits 31:0 and keeps bits 63:32.
- R11: The overflow status is set-by-one at 0x03 and clear-by-one at 0x04, and both addresses read the status. A new overflow in the same cycle as a clear leaves the bit set.
- R12: A chained advance appears in the same cycle as the overflow of the even partner.
- R13: A register write to a counter takes priority over an advance of that counter in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Register write address |
| wr_data | input | 64 | Register write data |
| wr_narrow | input | 1 | Counter write affects the low 32 bits only |
| rd_addr | input | 7 | Register read address |
| rd_data | output | 64 | Combinational read data |
| evt_valid | input | 1 | Event pulse strobe |
| evt_num | input | 16 | Event number of the pulse |
| irq | output | 1 | Level overflow interrupt |

## Verification
The bound checker watches several properties on every cycle. It checks that the cycle counter advances by exactly one whenever it is enabled and not being written, and that it holds still when the run bit is low. It checks that the cycle counter clears after a clear command and that a low-half wrap sets status bit 31 when LC is 0. It also checks that status bits stay set unless a clear is written, and that irq is never high without the run bit and a pending status bit.

Some behaviour only the bench scenarios can show. This includes event matching under both mask widths and chaining into the odd partner within the same cycle. It also includes LP suppressing chaining, narrow writes keeping the upper half, the priority of writes over advances, and random event streams compared against a counting model.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int          CYC_IDX     = 31;
    localparam int          ADDR_W      = 7;

    localparam logic [15:0] EV_SOFT     = 16'h0000;
    localparam logic [15:0] EV_CHAIN    = 16'h001E;

    localparam int          CB_RUN      = 0;
    localparam int          CB_CLRPROG  = 1;
    localparam int          CB_CLRCYC   = 2;
    localparam int          CB_LC       = 6;
    localparam int          CB_LP       = 7;
    localparam int          NF_LSB      = 11;

    localparam logic [ADDR_W-1:0] A_CTRL    = 7'h00;
    localparam logic [ADDR_W-1:0] A_EN_SET  = 7'h01;
    localparam logic [ADDR_W-1:0] A_EN_CLR  = 7'h02;
    localparam logic [ADDR_W-1:0] A_OVS_SET = 7'h03;
    localparam logic [ADDR_W-1:0] A_OVS_CLR = 7'h04;
    localparam logic [ADDR_W-1:0] A_IE_SET  = 7'h05;
    localparam logic [ADDR_W-1:0] A_IE_CLR  = 7'h06;
    localparam logic [ADDR_W-1:0] A_SWINC   = 7'h07;
    localparam logic [ADDR_W-1:0] A_TYPE0   = 7'h20;
    localparam logic [ADDR_W-1:0] A_CNT0    = 7'h40;
    localparam logic [ADDR_W-1:0] A_CYC     = 7'h5F;

    typedef struct packed {
        logic [4:0] nfield;
        logic       lp;
        logic       lc;
        logic       run;
    } ctrl_t;

    function automatic logic [31:0] valid_mask(input logic [4:0] n, input int nprog);
        logic [31:0] m;
        m = '0;
        for (int k = 0; k < 31; k++)
            if (k < int'(n) && k < nprog) m[k] = 1'b1;
        m[CYC_IDX] = 1'b1;
        return m;
    endfunction

    function automatic logic [63:0] ctrl_word(input ctrl_t c);
        logic [63:0] w;
        w = '0;
        w[NF_LSB +: 5] = c.nfield;
        w[CB_LP]       = c.lp;
        w[CB_LC]       = c.lc;
        w[CB_RUN]      = c.run;
        return w;
    endfunction

endpackage

// File: rtl/pmc_match.sv
module pmc_match #(
    parameter logic [15:0] EVT_MASK = 16'hFFFF
) (
    input  logic        enabled,
    input  logic [15:0] evtype,
    input  logic        evt_valid,
    input  logic [15:0] evt_num,
    input  logic        sw_hit,
    input  logic        chain_in,
    output logic        inc
);
    import pmc_pkg::*;

    logic hw_hit, soft_hit, chain_hit;

    always_comb begin
        hw_hit    = evt_valid && ((evt_num & EVT_MASK) == evtype);
        soft_hit  = sw_hit && (evtype == EV_SOFT);
        chain_hit = chain_in && (evtype == EV_CHAIN);
        inc       = enabled && (hw_hit || soft_hit || chain_hit);
    end

endmodule

// File: rtl/pmc_slice.sv
module pmc_slice #(
    parameter int STORE64 = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        inc,
    input  logic        ovf64,
    input  logic        clr,
    input  logic        wr_full,
    input  logic        wr_lo,
    input  logic [63:0] wr_data,
    output logic [63:0] value,
    output logic        ovf
);
    localparam logic [63:0] KEEP = (STORE64 != 0) ? '1 : 64'h0000_0000_FFFF_FFFF;

    logic [63:0] nxt;
    logic        busy_wr;

    always_comb begin
        nxt     = (value + 64'd1) & KEEP;
        busy_wr = clr || wr_full || wr_lo;
        ovf     = inc && !busy_wr && (ovf64 ? (nxt == '0) : (nxt[31:0] == '0));
    end

    always_ff @(posedge clk) begin
        if (rst)          value <= '0;
        else if (clr)     value <= '0;
        else if (wr_full) value <= wr_data & KEEP;
        else if (wr_lo)   value <= {value[63:32], wr_data[31:0]} & KEEP;
        else if (inc)     value <= nxt;
    end

endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
    import pmc_pkg::*;
#(
    parameter int NUM_PROG = 6,
    parameter int WIDE_CTR = 1,
    parameter int EVT_WIDE = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [6:0]  wr_addr,
    input  logic [63:0] wr_data,
    input  logic        wr_narrow,
    input  logic [6:0]  rd_addr,
    output logic [63:0] rd_data,
    input  logic        evt_valid,
    input  logic [15:0] evt_num,
    output logic        irq
);
    localparam logic [15:0] EVT_MASK = (EVT_WIDE != 0) ? 16'hFFFF : 16'h03FF;
    localparam logic [31:0] IMPL     = valid_mask(5'd31, NUM_PROG);

    ctrl_t        ctrl_q;
    logic [31:0]  cnten_q, ovs_q, inten_q;
    logic [31:0]  ovf_vec, vmask, vmask_wr, wd;
    logic [15:0]  type_q [NUM_PROG];
    logic [63:0]  cval   [NUM_PROG];
    logic [NUM_PROG-1:0] prog_ovf;
    logic [63:0]  cyc_val;
    logic         cyc_ovf, cyc_inc;
    logic         w_ctrl, w_en_set, w_en_clr, w_ovs_set, w_ovs_clr;
    logic         w_ie_set, w_ie_clr, w_sw, w_cyc, clr_cyc;

    always_comb begin
        wd        = wr_data[31:0];
        w_ctrl    = wr_en && (wr_addr == A_CTRL);
        w_en_set  = wr_en && (wr_addr == A_EN_SET);
        w_en_clr  = wr_en && (wr_addr == A_EN_CLR);
        w_ovs_set = wr_en && (wr_addr == A_OVS_SET);
        w_ovs_clr = wr_en && (wr_addr == A_OVS_CLR);
        w_ie_set  = wr_en && (wr_addr == A_IE_SET);
        w_ie_clr  = wr_en && (wr_addr == A_IE_CLR);
        w_sw      = wr_en && (wr_addr == A_SWINC);
        w_cyc     = wr_en && (wr_addr == A_CYC);
        vmask     = valid_mask(ctrl_q.nfield, NUM_PROG);
        vmask_wr  = valid_mask(wr_data[NF_LSB +: 5], NUM_PROG);
        clr_cyc   = w_ctrl && wr_data[CB_CLRCYC];
        cyc_inc   = ctrl_q.run && cnten_q[CYC_IDX];
    end

    // control, enable, status and interrupt-enable registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '{nfield: 5'(NUM_PROG), lp: 1'b0, lc: 1'b0, run: 1'b0};
            cnten_q <= '0;
            ovs_q   <= '0;
            inten_q <= '0;
        end else begin
            if (w_ctrl) begin
                ctrl_q.nfield <= wr_data[NF_LSB +: 5];
                ctrl_q.lp     <= (WIDE_CTR != 0) && wr_data[CB_LP];
                ctrl_q.lc     <= wr_data[CB_LC];
                ctrl_q.run    <= wr_data[CB_RUN];
            end
            cnten_q <= (cnten_q | (w_en_set ? (wd & IMPL) : '0)) & ~(w_en_clr ? wd : '0);
            inten_q <= (inten_q | (w_ie_set ? (wd & IMPL) : '0)) & ~(w_ie_clr ? wd : '0);
            ovs_q   <= ((ovs_q | (w_ovs_set ? (wd & IMPL) : '0)) & ~(w_ovs_clr ? wd : '0))
                       | ovf_vec;
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < NUM_PROG; k++) begin
            if (rst)
                type_q[k] <= EV_SOFT;
            else if (wr_en && (wr_addr == 7'(A_TYPE0 + k)))
                type_q[k] <= wr_data[15:0] & EVT_MASK;
        end
    end

    for (genvar i = 0; i < NUM_PROG; i++) begin : g_ctr
        logic inc_l, ovf_l, chain_l, wsel;

        if (i % 2 == 1) begin : g_odd
            assign chain_l = g_ctr[i-1].ovf_l && !ctrl_q.lp;
        end else begin : g_even
            assign chain_l = 1'b0;
        end

        assign wsel        = wr_en && (wr_addr == 7'(A_CNT0 + i));
        assign prog_ovf[i] = ovf_l;

        pmc_match #(.EVT_MASK(EVT_MASK)) u_match (
            .enabled  (ctrl_q.run && cnten_q[i] && vmask[i]),
            .evtype   (type_q[i]),
            .evt_valid(evt_valid),
            .evt_num  (evt_num),
            .sw_hit   (w_sw && wr_data[i]),
            .chain_in (chain_l),
            .inc      (inc_l)
        );

        pmc_slice #(.STORE64(WIDE_CTR)) u_slice (
            .clk    (clk),
            .rst    (rst),
            .inc    (inc_l),
            .ovf64  (ctrl_q.lp),
            .clr    (w_ctrl && wr_data[CB_CLRPROG] && vmask_wr[i]),
            .wr_full(wsel && !wr_narrow),
            .wr_lo  (wsel && wr_narrow),
            .wr_data(wr_data),
            .value  (cval[i]),
            .ovf    (ovf_l)
        );
    end

    pmc_slice #(.STORE64(1)) u_cycle (
        .clk    (clk),
        .rst    (rst),
        .inc    (cyc_inc),
        .ovf64  (ctrl_q.lc),
        .clr    (clr_cyc),
        .wr_full(w_cyc),
        .wr_lo  (1'b0),
        .wr_data(wr_data),
        .value  (cyc_val),
        .ovf    (cyc_ovf)
    );

    always_comb begin
        ovf_vec                 = '0;
        ovf_vec[NUM_PROG-1:0]   = prog_ovf;
        ovf_vec[CYC_IDX]        = cyc_ovf;
        irq                     = ctrl_q.run && ((ovs_q & inten_q) != '0);
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL:               rd_data = ctrl_word(ctrl_q);
            A_EN_SET,  A_EN_CLR:  rd_data = {32'b0, cnten_q};
            A_OVS_SET, A_OVS_CLR: rd_data = {32'b0, ovs_q};
            A_IE_SET,  A_IE_CLR:  rd_data = {32'b0, inten_q};
            A_CYC:                rd_data = cyc_val;
            default:              rd_data = '0;
        endcase
        for (int k = 0; k < NUM_PROG; k++) begin
            if (rd_addr == 7'(A_TYPE0 + k)) rd_data = {48'b0, type_q[k]};
            if (rd_addr == 7'(A_CNT0 + k))  rd_data = cval[k];
        end
    end

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker
    import pmc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [6:0]  wr_addr,
    input logic [63:0] wr_data,
    input logic        run,
    input logic        lc,
    input logic        cyc_en,
    input logic [31:0] ovs,
    input logic        irq,
    input logic [63:0] cyc_val
);

    assert_cyc_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_en) |=> $stable(cyc_val));

    assert_cyc_step_R3: assert property (@(posedge clk) disable iff (rst)
        (run && cyc_en && !wr_en) |=> (cyc_val == $past(cyc_val) + 64'd1));

    assert_cyc_wrap32_R4: assert property (@(posedge clk) disable iff (rst)
        (run && cyc_en && !wr_en && !lc && (cyc_val[31:0] == 32'hFFFF_FFFF)) |=> ovs[CYC_IDX]);

    assert_cyc_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == A_CTRL) && wr_data[CB_CLRCYC]) |=> (cyc_val == 64'd0));

    assert_irq_cause_R9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (run && (ovs != 32'd0)));

    assert_ovs_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (wr_addr == A_OVS_CLR)) |=> ((ovs & $past(ovs)) == $past(ovs)));

endmodule

bind pmc_bank pmc_checker u_pmc_checker (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .run    (ctrl_q.run),
    .lc     (ctrl_q.lc),
    .cyc_en (cnten_q[31]),
    .ovs    (ovs_q),
    .irq    (irq),
    .cyc_val(cyc_val)
);

// File: tb/tb_pmc_bank.sv
`timescale 1ns/1ps
module tb_pmc_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic        wr_narrow = 1'b0;
    logic [6:0]  rd_addr = '0;
    logic        evt_valid = 1'b0;
    logic [15:0] evt_num = '0;
    logic [63:0] rd_a, rd_b, ra, rb;
    logic        irq_a, irq_b;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    int          model [5];

    always #2 clk = ~clk;

    pmc_bank #(.NUM_PROG(6), .WIDE_CTR(1), .EVT_WIDE(1)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_narrow(wr_narrow), .rd_addr(rd_addr), .rd_data(rd_a),
        .evt_valid(evt_valid), .evt_num(evt_num), .irq(irq_a));

    pmc_bank #(.NUM_PROG(6), .WIDE_CTR(0), .EVT_WIDE(0)) dut_b (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_narrow(wr_narrow), .rd_addr(rd_addr), .rd_data(rd_b),
        .evt_valid(evt_valid), .evt_num(evt_num), .irq(irq_b));

    function automatic logic [63:0] cw(bit run, bit cp, bit cc, bit lc, bit lp, int n);
        return 64'(run) | (64'(cp) << 1) | (64'(cc) << 2) | (64'(lc) << 6) |
               (64'(lp) << 7) | (64'(n) << 11);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [63:0] d, input bit nar = 1'b0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_narrow = nar;
        @(negedge clk);
        wr_en = 1'b0; wr_narrow = 1'b0;
    endtask

    task automatic ev(input logic [15:0] n);
        @(negedge clk);
        evt_valid = 1'b1; evt_num = n;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic wr_ev(input logic [6:0] a, input logic [63:0] d, input logic [15:0] n);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; evt_valid = 1'b1; evt_num = n;
        @(negedge clk);
        wr_en = 1'b0; evt_valid = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a);
        rd_addr = a;
        #1;
        ra = rd_a; rb = rd_b;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // reset state (R8: N resets to 6)
        rd(7'h00); chk("R8 reset ctrl a", ra, 64'h3000); chk("R8 reset ctrl b", rb, 64'h3000);
        rd(7'h03); chk("R11 reset ovs", ra, 64'h0);
        #1; chk("R9 reset irq", 64'(irq_a), 64'h0);

        // R1 gating by run bit and enable mask
        wr(7'h20, 64'h11); wr(7'h01, 64'h1);
        ev(16'h11); rd(7'h40); chk("R1 no run", ra, 64'h0);
        wr(7'h00, cw(1,0,0,0,0,6));
        ev(16'h11); rd(7'h40); chk("R1 run a", ra, 64'h1); chk("R1 run b", rb, 64'h1);
        wr(7'h02, 64'h1);
        ev(16'h11); rd(7'h40); chk("R1 disabled", ra, 64'h1);
        wr(7'h01, 64'h1);

        // R2 event mask width
        wr(7'h20, 64'h1011);
        rd(7'h20); chk("R2 type a", ra, 64'h1011); chk("R2 type b", rb, 64'h0011);
        ev(16'h0011); rd(7'h40); chk("R2 wide no match", ra, 64'h1); chk("R2 narrow match", rb, 64'h2);

        // R3 storage width, R10 narrow write
        wr(7'h40, 64'h1_FFFF_FFFE);
        rd(7'h40); chk("R3 wide store", ra, 64'h1_FFFF_FFFE); chk("R3 32b store", rb, 64'hFFFF_FFFE);
        wr(7'h40, 64'hABCD_0000_0000_0005, 1'b1);
        rd(7'h40); chk("R10 narrow keeps upper", ra, 64'h1_0000_0005); chk("R10 narrow b", rb, 64'h5);

        // R5 / R12 chaining
        wr(7'h20, 64'h11); wr(7'h21, 64'h1E); wr(7'h41, 64'h7); wr(7'h01, 64'h3);
        wr(7'h40, 64'hFFFF_FFFF);
        ev(16'h11);
        rd(7'h41); chk("R12 chain same cycle a", ra, 64'h8); chk("R5 chain b", rb, 64'h8);
        rd(7'h40); chk("R4 low wrap a", ra, 64'h1_0000_0000); chk("R3 wrap b", rb, 64'h0);
        rd(7'h03); chk("R4 ovs a", ra, 64'h1); chk("R4 ovs b", rb, 64'h1);

        // R4 / R7 LP behaviour
        wr(7'h04, 64'hFFFF_FFFF);
        wr(7'h00, cw(1,0,0,0,1,6));
        rd(7'h00); chk("R7 LP kept a", ra, 64'h3081); chk("R7 LP forced b", rb, 64'h3001);
        wr(7'h40, 64'hFFFF_FFFF);
        ev(16'h11);
        rd(7'h03); chk("R4 LP no ovf a", ra, 64'h0); chk("R4 b ovf", rb, 64'h1);
        rd(7'h41); chk("R5 LP no chain a", ra, 64'h8); chk("R5 chain b", rb, 64'h9);
        wr(7'h40, 64'hFFFF_FFFF_FFFF_FFFF);
        ev(16'h11);
        rd(7'h40); chk("R4 64b wrap a", ra, 64'h0);
        rd(7'h03); chk("R4 64b ovs a", ra, 64'h1);
        rd(7'h41); chk("R5 LP still no chain a", ra, 64'h8); chk("R5 chain b2", rb, 64'hA);

        // R6 software increment
        wr(7'h00, cw(1,0,0,0,0,6)); wr(7'h04, 64'hFFFF_FFFF);
        wr(7'h01, 64'h4);
        wr(7'h07, 64'hC);
        rd(7'h42); chk("R6 sw inc", ra, 64'h1);
        rd(7'h43); chk("R6 disabled untouched", ra, 64'h0);

        // R8 valid mask
        wr(7'h00, cw(1,0,0,0,0,2));
        rd(7'h00); chk("R8 N field", ra, 64'h1001);
        wr(7'h07, 64'h4);
        rd(7'h42); chk("R8 outside N", ra, 64'h1);
        ev(16'h11); rd(7'h40); chk("R8 inside N", ra, 64'h1); chk("R8 inside N b", rb, 64'h1);
        wr(7'h00, cw(1,0,0,0,0,6));

        // R7 clears
        wr(7'h00, cw(1,1,0,0,0,6));
        rd(7'h40); chk("R7 P clears 0", ra, 64'h0);
        rd(7'h42); chk("R7 P clears 2", ra, 64'h0);
        rd(7'h00); chk("R7 P not stored", ra, 64'h3001);
        wr(7'h01, 64'h8000_0000);
        repeat (3) @(negedge clk);
        wr(7'h00, cw(1,0,1,0,0,6));
        rd(7'h5F); chk("R7 C clears cycle", ra, 64'h0);
        rd(7'h00); chk("R7 C not stored", ra, 64'h3001);

        // R4 cycle counter overflow width
        wr(7'h04, 64'hFFFF_FFFF);
        wr(7'h5F, 64'hFFFF_FFFE);
        repeat (4) @(negedge clk);
        rd(7'h03); chk("R4 cyc 32b ovf", ra, 64'h8000_0000);
        wr(7'h00, cw(1,0,0,1,0,6)); wr(7'h04, 64'hFFFF_FFFF);
        wr(7'h5F, 64'hFFFF_FFFE);
        repeat (4) @(negedge clk);
        rd(7'h03); chk("R4 cyc LC no ovf", ra, 64'h0);
        wr(7'h5F, 64'hFFFF_FFFF_FFFF_FFFE);
        repeat (4) @(negedge clk);
        rd(7'h03); chk("R4 cyc LC 64b ovf", ra, 64'h8000_0000);
        wr(7'h02, 64'h8000_0000);

        // R9 interrupt
        wr(7'h05, 64'h8000_0000); #1; chk("R9 irq on", 64'(irq_a), 64'h1);
        wr(7'h00, cw(0,0,0,1,0,6)); #1; chk("R9 irq off run", 64'(irq_a), 64'h0);
        wr(7'h00, cw(1,0,0,1,0,6)); #1; chk("R9 irq back", 64'(irq_a), 64'h1);
        wr(7'h06, 64'h8000_0000); #1; chk("R9 irq masked", 64'(irq_a), 64'h0);

        // R11 status views
        wr(7'h04, 64'hFFFF_FFFF);
        wr(7'h03, 64'h5); rd(7'h04); chk("R11 set", ra, 64'h5);
        wr(7'h04, 64'h1); rd(7'h03); chk("R11 clear", ra, 64'h4);
        wr(7'h03, 64'h1);
        wr(7'h40, 64'hFFFF_FFFF);
        wr_ev(7'h04, 64'h1, 16'h11);
        rd(7'h03); chk("R11 ovf beats clear a", ra, 64'h5); chk("R11 ovf beats clear b", rb, 64'h5);

        // R13 write priority
        wr_ev(7'h40, 64'h40, 16'h11);
        rd(7'h40); chk("R13 write wins a", ra, 64'h40); chk("R13 write wins b", rb, 64'h40);

        // R1 / R2 random event stream against counting model
        wr(7'h00, cw(1,1,0,0,0,6));
        for (int k = 0; k < 6; k++) wr(7'(32 + k), 64'(16'h21 + (k % 3)));
        wr(7'h01, 64'h3F);
        for (int k = 0; k < 5; k++) model[k] = 0;
        for (int it = 0; it < 300; it++) begin
            @(negedge clk);
            evt_valid = 1'($urandom % 2);
            evt_num   = 16'h20 + 16'($urandom % 5);
            if (evt_valid) model[evt_num - 16'h20]++;
        end
        @(negedge clk);
        evt_valid = 1'b0;
        for (int k = 0; k < 6; k++) begin
            rd(7'(64 + k));
            chk($sformatf("R2 random ctr%0d a", k), ra, 64'(model[1 + (k % 3)]));
            chk($sformatf("R1 random ctr%0d b", k), rb, 64'(model[1 + (k % 3)]));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule